// File: doc/BRIEF.md
# NAND Flash Host Command Interface

This block connects a simple register bus to an 8-bit NAND flash device. Software writes command bytes, address bytes, data bytes and read requests into a small queue of pending operations. A strobe sequencer then replays those operations on the flash pins one at a time. Each operation drives the latch-enable lines that select its cycle type and pulses the write or read strobe.

A flash read takes two steps. Software first writes any value to the read-request register, which queues one read strobe. The flash byte is latched at the end of the strobe's low phase, and a sticky read-ready flag is raised. Software then fetches the byte from the read-data register and clears the flag by writing 1 to it. Software polls the queue-full and queue-empty status bits to pace its writes and to learn when the queue has drained. Strobe low times come from a control register.

Top module: `nand_host_if`

## Requirements
- R1: After reset, status (offset 1) reads 0x11 while the ready input is high, interrupt status (offset 2) and control (offset 0) read 0, the write, read and chip-enable strobes are high, and both latch enables are low.
- R2: A write to offset 3 produces one flash write cycle with the command latch high. A write to offset 4 produces one with the address latch high. A write to offset 5 produces one with neither latch high. The byte is driven on the data pins, and cycles leave in the order they were written.
- R3: The write strobe stays low for (control bits 3:0) + 1 clocks, and the strobes are high for at least one clock between two queued operations.
- R4: Any write to offset 6 queues a read. The read strobe stays low for (control bits 7:4) + 1 clocks. The flash byte is latched into the read-data register (offset 7, bits 7:0), and interrupt-status bit 3 is set.
- R5: Interrupt-status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: Status bit 0 follows the ready input. Interrupt-status bit 0 is set when the ready input rises.
- R7: The queue holds 4 operations, and status bit 1 is set while it is full. A queued write made while it is full is dropped and sets interrupt-status bit 1.
- R8: Status bit 2 is set while a data write is queued or on the pins. Status bit 3 is set while a read is queued or on the pins. Interrupt-status bit 4 is set when a data-write strobe finishes with nothing left queued.
- R9: Status bit 4 is set when the queue is empty and no strobe is active. Interrupt-status bit 2 is set on the clock where status bit 4 becomes set.
- R10: Control keeps bits 9:0 (bit 8 data-width flag, bit 9 page-size flag) and reads zero above them.
- R11: Offsets 3 to 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write offset |
| reg_wdata | input | BUS_W | Write data |
| reg_raddr | input | 3 | Read offset |
| reg_rdata | output | BUS_W | Read data, combinational from reg_raddr |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_ce_n | output | 1 | Chip enable, low while a strobe cycle runs |
| fl_dq_out | output | 8 | Byte driven toward the flash |
| fl_dq_oe | output | 1 | Data pin drive enable |
| fl_dq_in | input | 8 | Byte from the flash |
| fl_rdy | input | 1 | Flash ready, high when not busy |

## Verification
A register write takes effect at the clock edge that samples it, and the status and readback values can be seen in the same cycle after that edge. A queued operation starts its low phase one clock after it is pushed, if the sequencer is idle. The low phase lasts delay+1 clocks. The captured byte and the read-ready flag update at the edge that ends the low phase, and chip enable then stays low for one more clock of strobe-high hold. The bench therefore never relies on fixed waits for strobe results: it polls the status and interrupt-status bits, and it measures strobe widths in a flash stub that samples the pins at every edge. All bus accesses are driven and read at the falling edge.

// File: rtl/nhi_pkg.sv
package nhi_pkg;

   localparam int unsigned ENT_DW = 8;

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_DWR  = 2'd2,
      OP_RD   = 2'd3
   } nhi_op_e;

   typedef struct packed {
      nhi_op_e           op;
      logic [ENT_DW-1:0] dat;
   } nhi_ent_t;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_STAT  = 3'd1;
   localparam logic [2:0] A_ISTAT = 3'd2;
   localparam logic [2:0] A_CMD   = 3'd3;
   localparam logic [2:0] A_ADDR  = 3'd4;
   localparam logic [2:0] A_DWR   = 3'd5;
   localparam logic [2:0] A_RDREQ = 3'd6;
   localparam logic [2:0] A_RDATA = 3'd7;

   localparam int unsigned IRQ_W = 5;

endpackage

// File: rtl/nhi_wbuf.sv
module nhi_wbuf
   import nhi_pkg::*;
#(
   parameter int unsigned DEPTH = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  nhi_ent_t push_ent,
   input  logic     pop,
   output nhi_ent_t pop_ent,
   output logic     full,
   output logic     empty,
   output logic     has_dwr,
   output logic     has_rd
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("nhi_wbuf: DEPTH must be at least 2");
      end
   endgenerate

   logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0] cnt_q;
   nhi_ent_t      mem_q [DEPTH];
   logic          push_ok, pop_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign pop_ent = mem_q[rp_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_nx;
         if (pop_ok)  rp_q <= rp_nx;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= push_ent;
   end

   // per-slot occupancy scan for the pending-operation flags
   logic [DEPTH-1:0] hit_w, hit_r;
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      int   off;
      logic occ;
      always_comb begin
         off = (i >= int'(rp_q)) ? (i - int'(rp_q)) : (i + int'(DEPTH) - int'(rp_q));
         occ = (off < int'(cnt_q));
         hit_w[i] = occ && (mem_q[i].op == OP_DWR);
         hit_r[i] = occ && (mem_q[i].op == OP_RD);
      end
   end

   assign has_dwr = |hit_w;
   assign has_rd  = |hit_r;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R7
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full); // R7

endmodule

// File: rtl/nhi_strobe.sv
module nhi_strobe
   import nhi_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_avail,
   input  nhi_ent_t          ent,
   input  logic [DLY_W-1:0]  wr_dly,
   input  logic [DLY_W-1:0]  rd_dly,
   output logic              pop,
   output logic              cap_stb,
   output logic              dwr_done,
   output logic              idle,
   output logic              act_dwr,
   output logic              act_rd,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic              ce_n,
   output logic              dq_oe,
   output logic [ENT_DW-1:0] dq_out
);

   generate
      if (DLY_W < 1) begin : g_bad_dly
         $error("nhi_strobe: DLY_W must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

   st_e              st_q;
   logic [DLY_W-1:0] cnt_q;
   nhi_ent_t         cur_q;
   logic             active, is_rd;

   assign active = (st_q != ST_IDLE);
   assign is_rd  = (cur_q.op == OP_RD);
   assign pop    = (st_q == ST_IDLE) && ent_avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         cur_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (ent_avail) begin
               cur_q <= ent;
               cnt_q <= (ent.op == OP_RD) ? rd_dly : wr_dly;
               st_q  <= ST_LOW;
            end
            ST_LOW: begin
               if (cnt_q == '0) st_q <= ST_HIGH;
               else             cnt_q <= cnt_q - 1'b1;
            end
            ST_HIGH: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle     = !active;
   assign act_dwr  = active && (cur_q.op == OP_DWR);
   assign act_rd   = active && is_rd;
   assign cap_stb  = (st_q == ST_LOW) && (cnt_q == '0) && is_rd;
   assign dwr_done = (st_q == ST_HIGH) && (cur_q.op == OP_DWR);

   assign cle    = active && (cur_q.op == OP_CMD);
   assign ale    = active && (cur_q.op == OP_ADDR);
   assign we_n   = !((st_q == ST_LOW) && !is_rd);
   assign re_n   = !((st_q == ST_LOW) && is_rd);
   assign ce_n   = !active;
   assign dq_oe  = active && !is_rd;
   assign dq_out = cur_q.dat;

   AST_LOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOW && cnt_q != '0) |=> (st_q == ST_LOW && cnt_q == $past(cnt_q) - 1'b1)); // R3
   AST_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH) |=> (we_n && re_n)); // R3
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R2

endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
   import nhi_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DLY_W = 4,
   parameter int unsigned BUS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_waddr,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_we_n,
   output logic              fl_re_n,
   output logic              fl_ce_n,
   output logic [ENT_DW-1:0] fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [ENT_DW-1:0] fl_dq_in,
   input  logic              fl_rdy
);

   localparam int unsigned CTRL_W = 2 * DLY_W + 2;
   localparam int unsigned B_WID  = 2 * DLY_W;
   localparam int unsigned B_PAGE = 2 * DLY_W + 1;

   generate
      if (BUS_W <= CTRL_W) begin : g_bad_bus
         $error("nand_host_if: BUS_W must exceed the control width");
      end
      if (BUS_W < IRQ_W) begin : g_bad_irq
         $error("nand_host_if: BUS_W too narrow for interrupt status");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [IRQ_W-1:0]  istat_q, irq_set, irq_clr;
   logic [ENT_DW-1:0] rdata_q;
   logic              rdy_prev_q, empty_prev_q;

   logic     push_try;
   nhi_ent_t push_ent;
   nhi_ent_t q_ent;
   logic     q_pop, q_full, q_empty, q_has_dwr, q_has_rd;
   logic     cap_stb, dwr_done, seq_idle, act_dwr, act_rd;
   logic     all_empty, pend_wr, pend_rd;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[BUS_W-1:CTRL_W];

   // queue decode: one operation type per queued offset
   always_comb begin
      push_try     = 1'b0;
      push_ent.op  = OP_CMD;
      push_ent.dat = reg_wdata[ENT_DW-1:0];
      if (reg_wr) begin
         case (reg_waddr)
            A_CMD:   begin push_try = 1'b1; push_ent.op = OP_CMD;  end
            A_ADDR:  begin push_try = 1'b1; push_ent.op = OP_ADDR; end
            A_DWR:   begin push_try = 1'b1; push_ent.op = OP_DWR;  end
            A_RDREQ: begin push_try = 1'b1; push_ent.op = OP_RD;   end
            default: ;
         endcase
      end
   end

   nhi_wbuf #(.DEPTH(DEPTH)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_try),
      .push_ent (push_ent),
      .pop      (q_pop),
      .pop_ent  (q_ent),
      .full     (q_full),
      .empty    (q_empty),
      .has_dwr  (q_has_dwr),
      .has_rd   (q_has_rd)
   );

   nhi_strobe #(.DLY_W(DLY_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_avail (!q_empty),
      .ent       (q_ent),
      .wr_dly    (ctrl_q[DLY_W-1:0]),
      .rd_dly    (ctrl_q[2*DLY_W-1:DLY_W]),
      .pop       (q_pop),
      .cap_stb   (cap_stb),
      .dwr_done  (dwr_done),
      .idle      (seq_idle),
      .act_dwr   (act_dwr),
      .act_rd    (act_rd),
      .cle       (fl_cle),
      .ale       (fl_ale),
      .we_n      (fl_we_n),
      .re_n      (fl_re_n),
      .ce_n      (fl_ce_n),
      .dq_oe     (fl_dq_oe),
      .dq_out    (fl_dq_out)
   );

   assign all_empty = q_empty && seq_idle;
   assign pend_wr   = q_has_dwr || act_dwr;
   assign pend_rd   = q_has_rd || act_rd;

   always_comb begin
      irq_set    = '0;
      irq_set[0] = fl_rdy && !rdy_prev_q;
      irq_set[1] = push_try && q_full;
      irq_set[2] = all_empty && !empty_prev_q;
      irq_set[3] = cap_stb;
      irq_set[4] = dwr_done && q_empty;
      irq_clr    = (reg_wr && reg_waddr == A_ISTAT) ? reg_wdata[IRQ_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         istat_q      <= '0;
         rdata_q      <= '0;
         rdy_prev_q   <= 1'b1;
         empty_prev_q <= 1'b1;
      end else begin
         if (reg_wr && reg_waddr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
         istat_q      <= (istat_q & ~irq_clr) | irq_set;
         if (cap_stb) rdata_q <= fl_dq_in;
         rdy_prev_q   <= fl_rdy;
         empty_prev_q <= all_empty;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
         A_STAT:  reg_rdata[4:0] = {all_empty, pend_rd, pend_wr, q_full, fl_rdy};
         A_ISTAT: reg_rdata[IRQ_W-1:0] = istat_q;
         A_RDATA: reg_rdata[ENT_DW-1:0] = rdata_q;
         default: reg_rdata = '0;
      endcase
   end

   logic unused_flags;
   assign unused_flags = ctrl_q[B_WID] ^ ctrl_q[B_PAGE];

   AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_rdy) |=> istat_q[0]); // R6
   AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (push_try && q_full) |=> istat_q[1]); // R7
   AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (istat_q[3] && rdata_q == $past(fl_dq_in))); // R4

endmodule

// File: tb/nand_host_if_tb.sv
`timescale 1ns/1ps
module nand_host_if_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [15:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [15:0] reg_rdata;
   logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_ce_n, fl_dq_oe;
   logic [7:0]  fl_dq_out, fl_dq_in;
   logic        fl_rdy = 1'b1;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   nand_host_if u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
      .fl_ce_n(fl_ce_n), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .fl_dq_in(fl_dq_in), .fl_rdy(fl_rdy)
   );

   function automatic logic [7:0] pat(int n);
      logic [7:0] x;
      x = 8'(n);
      return x * 8'd37 + 8'd5;
   endfunction

   // flash stub: logs write cycles, serves read bytes, measures strobes
   logic [1:0] log_t [512];
   logic [7:0] log_d [512];
   int  nlog = 0, nrd = 0;
   int  we_lo = 0, re_lo = 0, last_we_w = 0, last_re_w = 0;
   int  hi_run = 0, min_gap = 1000;
   bit  seen_strobe = 0;
   logic we_p = 1'b1, re_p = 1'b1;

   assign fl_dq_in = pat(nrd);

   always @(posedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) we_lo++;
         if (!fl_re_n) re_lo++;
         if (fl_we_n && fl_re_n) hi_run++;
         if ((we_p && !fl_we_n) || (re_p && !fl_re_n)) begin
            if (seen_strobe && hi_run < min_gap) min_gap = hi_run;
            seen_strobe = 1;
            hi_run = 0;
         end
         if (fl_we_n && !we_p) begin
            log_t[nlog] = fl_cle ? 2'd0 : (fl_ale ? 2'd1 : 2'd2);
            log_d[nlog] = fl_dq_out;
            nlog++;
            last_we_w = we_lo;
            we_lo = 0;
         end
         if (fl_re_n && !re_p) begin
            nrd++;
            last_re_w = re_lo;
            re_lo = 0;
         end
      end
      we_p = fl_we_n;
      re_p = fl_re_n;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bw(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic br(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   task automatic poll(input logic [2:0] a, input int b, input logic v, output bit ok);
      logic [15:0] d;
      ok = 0;
      for (int k = 0; k < 400; k++) begin
         br(a, d);
         if (d[b] === v) begin ok = 1; break; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      bit ok;
      int base, nexp, rd_idx, wd, rdd, r;
      logic [1:0] exp_t [256];
      logic [7:0] exp_d [256];

      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      br(3'd1, d); chk("R1 status", d, 16'h0011);
      br(3'd2, d); chk("R1 istat", d, 16'h0000);
      br(3'd0, d); chk("R1 ctrl", d, 16'h0000);
      chk("R1 pins", {fl_we_n, fl_re_n, fl_ce_n, fl_cle, fl_ale}, 5'b11100);

      // R10 control readback
      bw(3'd0, 16'hFFFF); br(3'd0, d); chk("R10 ctrl mask", d, 16'h03FF);
      bw(3'd0, 16'h0332); br(3'd0, d); chk("R10 ctrl value", d, 16'h0332);

      // R11 queue offsets read zero
      br(3'd3, d); chk("R11 cmd read", d, 0);
      br(3'd6, d); chk("R11 rdreq read", d, 0);

      // R2 command/address/data cycles, R3 write low width (wr delay 2)
      bw(3'd3, 16'h0090); bw(3'd4, 16'h0000); bw(3'd5, 16'h00A5);
      poll(3'd1, 4, 1'b1, ok); chk("R9 drained", ok, 1);
      chk("R2 count", nlog, 3);
      chk("R2 cmd", {log_t[0], log_d[0]}, {2'd0, 8'h90});
      chk("R2 addr", {log_t[1], log_d[1]}, {2'd1, 8'h00});
      chk("R2 data", {log_t[2], log_d[2]}, {2'd2, 8'hA5});
      chk("R3 we width", last_we_w, 3);

      // R9 empty edge, R8 write done, R5 write-1-clear
      br(3'd2, d); chk("R9 empty edge flag", d[2], 1);
      chk("R8 write done flag", d[4], 1);
      bw(3'd2, 16'h0000); br(3'd2, d); chk("R5 zero keeps", d[4], 1);
      bw(3'd2, 16'h0004); br(3'd2, d); chk("R5 clear bit2", d[2], 0);
      chk("R5 others kept", d[4], 1);
      bw(3'd2, 16'h001F); br(3'd2, d); chk("R5 clear all", d, 0);

      // R8 page-write pending
      bw(3'd0, 16'h000F);
      bw(3'd5, 16'h003C); br(3'd1, d); chk("R8 write pending", d[2], 1);
      poll(3'd1, 4, 1'b1, ok);
      br(3'd1, d); chk("R8 write pending cleared", d[2], 0);
      chk("R3 we width 15", last_we_w, 16);

      // R4 read path (rd delay 5)
      bw(3'd0, 16'h0050);
      bw(3'd6, 16'h1234); br(3'd1, d); chk("R8 read pending", d[3], 1);
      poll(3'd2, 3, 1'b1, ok); chk("R4 ready flag", ok, 1);
      br(3'd7, d); chk("R4 read byte", d, {8'h00, pat(0)});
      chk("R4 re width", last_re_w, 6);
      rd_idx = 1;
      bw(3'd2, 16'h0008); br(3'd2, d); chk("R5 clear ready", d[3], 0);
      bw(3'd2, 16'h001F);

      // R7 overflow: wr delay 15, six back-to-back data writes
      bw(3'd0, 16'h000F);
      base = nlog;
      for (int i = 0; i < 5; i++) bw(3'd5, 16'(8'h10 + i));
      br(3'd1, d); chk("R7 full", d[1], 1);
      bw(3'd5, 16'h00EE);
      poll(3'd1, 4, 1'b1, ok);
      chk("R7 accepted", nlog - base, 5);
      chk("R7 last kept", log_d[nlog-1], 8'h14);
      br(3'd2, d); chk("R7 overflow flag", d[1], 1);
      bw(3'd2, 16'h001F);

      // R6 ready follows pin
      @(negedge clk); fl_rdy = 1'b0;
      br(3'd1, d); chk("R6 busy", d[0], 0);
      bw(3'd2, 16'h001F);
      @(negedge clk); fl_rdy = 1'b1;
      repeat (2) @(negedge clk);
      br(3'd2, d); chk("R6 rise flag", d[0], 1);
      br(3'd1, d); chk("R6 ready", d[0], 1);
      bw(3'd2, 16'h001F);

      // random mix
      r = $urandom(32'h5EED);
      wd = $urandom % 4; rdd = $urandom % 4;
      bw(3'd0, 16'((rdd << 4) | wd));
      base = nlog; nexp = 0;
      for (int i = 0; i < 80; i++) begin
         int op;
         logic [7:0] b;
         op = $urandom % 4;
         b = 8'($urandom);
         poll(3'd1, 1, 1'b0, ok);
         if (op == 3) begin
            bw(3'd6, 16'h0000);
            poll(3'd2, 3, 1'b1, ok); chk("R4 random ready", ok, 1);
            br(3'd7, d); chk("R4 random byte", d, {8'h00, pat(rd_idx)});
            chk("R4 random re width", last_re_w, rdd + 1);
            rd_idx++;
            bw(3'd2, 16'h0008);
         end else begin
            bw(3'(3 + op), {8'h00, b});
            exp_t[nexp] = 2'(op);
            exp_d[nexp] = b;
            nexp++;
         end
      end
      poll(3'd1, 4, 1'b1, ok);
      chk("R2 random count", nlog - base, nexp);
      for (int i = 0; i < nexp; i++)
         chk("R2 random cycle", {log_t[base+i], log_d[base+i]}, {exp_t[i], exp_d[i]});
      chk("R3 strobe gap", (min_gap >= 1), 1);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule